// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers every exception request that a small CPU can take and reduces them to one vector address. The requests are three system reset causes, a non-maskable trap for unimplemented op-codes, a non-maskable software or debug interrupt, one request masked by the CPU's X bit, and a parameterized set of peripheral requests masked by the CPU's I bit. The block reports to the CPU whether any request is accepted under the current masks. When the CPU strobes a vector fetch, the block latches the address of the winning request. A request that has gone away by the time of the fetch yields a dedicated spurious vector.

The upper byte of each vector comes from a base register that software can write. The lower byte is a fixed offset for each source. A wake-up output asks the device to leave its stop or wait state. In either state the X-masked request raises this wake-up even while the X bit is set.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset the base register holds 0xFF, vec_addr_o is 0xFFFE, and req_pend_o is 0 while no request line is high.
- R2: An I-maskable source k has vector offset 0x80 + 2*(k+1). Among the pending I-maskable sources, the highest index wins.
- R3: While i_mask_i is 1, the I-maskable requests do not raise req_pend_o. A fetch taken while only these requests are present returns offset 0x80.
- R4: The X-maskable request has offset 0xF4 and wins over every I-maskable request. While x_mask_i is 1 it is ignored and the I-maskable winner is returned.
- R5: The unimplemented op-code trap (offset 0xF8) is accepted whatever the masks are. It wins over the software interrupt, the X-maskable request and the I-maskable requests.
- R6: The software/debug interrupt (offset 0xF6) is accepted whatever the masks are. It wins over the X-maskable request.
- R7: The reset causes rst_src_i bit0 (pin or low-voltage, 0xFE), bit1 (clock monitor, 0xFC) and bit2 (watchdog, 0xFA) win over every other source. Among them, bit0 has priority over bit1, and bit1 over bit2.
- R8: A write with wr_hi_i=1 loads wr_data_i into the base register, which supplies vec_addr_o[15:8] from the next fetch onward. A write with wr_hi_i=0 is ignored.
- R9: vec_addr_o changes only on a clock edge where vec_fetch_i is 1. It then holds {base, offset} for the request that wins in that cycle, or {base, 0x80} when no request is accepted.
- R10: While stop_mode_i or wait_mode_i is 1, wake_o is 1 whenever req_pend_o or xirq_i is 1, even if x_mask_i is 1. wake_o is 0 outside these states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_src_i | input | 3 | Reset causes: pin/low-voltage, clock monitor, watchdog |
| trap_i | input | 1 | Unimplemented op-code trap |
| swi_i | input | 1 | Software interrupt or debug request |
| xirq_i | input | 1 | X-maskable request |
| irq_i | input | N_IRQ | I-maskable peripheral requests |
| i_mask_i | input | 1 | CPU I bit |
| x_mask_i | input | 1 | CPU X bit |
| vec_fetch_i | input | 1 | Vector fetch strobe |
| stop_mode_i | input | 1 | Device in stop state |
| wait_mode_i | input | 1 | Device in wait state |
| wr_en_i | input | 1 | Base register write enable |
| wr_hi_i | input | 1 | Write targets the high address byte |
| wr_data_i | input | 8 | Write data |
| vec_addr_o | output | 16 | Latched vector address |
| req_pend_o | output | 1 | An accepted request is pending |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions take the request lines and masks to be synchronous levels that settle before the clock edge. They also take N_IRQ to be small enough that the peripheral offsets stay below 0xF4. The bench changes inputs only on the falling clock edge and keeps the default of eight peripheral sources. It never pulses a fetch while a base write to the same register is still being checked, so each vector it expects follows from one settled set of inputs.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned OFF_W = 8;

  localparam logic [OFF_W-1:0] OFF_RST_PIN  = 8'hFE;
  localparam logic [OFF_W-1:0] OFF_RST_CLK  = 8'hFC;
  localparam logic [OFF_W-1:0] OFF_RST_WDOG = 8'hFA;
  localparam logic [OFF_W-1:0] OFF_TRAP     = 8'hF8;
  localparam logic [OFF_W-1:0] OFF_SWI      = 8'hF6;
  localparam logic [OFF_W-1:0] OFF_XIRQ     = 8'hF4;
  localparam logic [OFF_W-1:0] OFF_SPUR     = 8'h80;

  function automatic logic [OFF_W-1:0] irq_offset(input int unsigned idx);
    return OFF_SPUR + OFF_W'(2 * (idx + 1));
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      if (req_i[k]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end

  // R2: winner is set and nothing above it is set
  always_comb begin
    if (valid_o) begin
      p_winner_top_r2: assert (req_i[idx_o] && ((req_i >> idx_o) >> 1) == '0);
    end
  end
endmodule

// File: rtl/irq_vec_base_reg.sv
module irq_vec_base_reg #(
  parameter int unsigned BASE_W = 8,
  parameter logic [BASE_W-1:0] BASE_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [BASE_W-1:0] wr_data_i,
  output logic [BASE_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 base_o <= BASE_RST;
    else if (wr_en_i && wr_hi_i) base_o <= wr_data_i;
  end

  p_low_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> $stable(base_o));
  p_high_write_loads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i) |=> base_o == $past(wr_data_i));
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [2:0]       rst_src_i,
  input  logic             trap_i,
  input  logic             swi_i,
  input  logic             xirq_i,
  input  logic             x_mask_i,
  input  logic             irq_valid_i,
  input  logic [IDX_W-1:0] irq_idx_i,
  input  logic             i_mask_i,
  output logic             pend_o,
  output logic [OFF_W-1:0] off_o
);
  always_comb begin
    pend_o = 1'b1;
    if      (rst_src_i[0])             off_o = OFF_RST_PIN;
    else if (rst_src_i[1])             off_o = OFF_RST_CLK;
    else if (rst_src_i[2])             off_o = OFF_RST_WDOG;
    else if (trap_i)                   off_o = OFF_TRAP;
    else if (swi_i)                    off_o = OFF_SWI;
    else if (xirq_i && !x_mask_i)      off_o = OFF_XIRQ;
    else if (irq_valid_i && !i_mask_i) off_o = irq_offset(int'(irq_idx_i));
    else begin
      pend_o = 1'b0;
      off_o  = OFF_SPUR;
    end
  end

  // R5, R6: non-maskable sources always pending
  always_comb begin
    if (trap_i || swi_i) p_nonmask_pend_r5: assert (pend_o);
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned BASE_W = ADDR_W - OFF_W,
  localparam int unsigned IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        rst_src_i,
  input  logic              trap_i,
  input  logic              swi_i,
  input  logic              xirq_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              i_mask_i,
  input  logic              x_mask_i,
  input  logic              vec_fetch_i,
  input  logic              stop_mode_i,
  input  logic              wait_mode_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [BASE_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              req_pend_o,
  output logic              wake_o
);
  logic              irq_valid;
  logic [IDX_W-1:0]  irq_idx;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  sel_off;
  logic              low_pwr;

  irq_prio_enc #(.N_IRQ(N_IRQ)) u_enc (
    .req_i   (irq_i),
    .valid_o (irq_valid),
    .idx_o   (irq_idx)
  );

  irq_vec_base_reg #(.BASE_W(BASE_W), .BASE_RST('1)) u_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .base_o    (base_q)
  );

  irq_vec_arb #(.N_IRQ(N_IRQ)) u_arb (
    .rst_src_i   (rst_src_i),
    .trap_i      (trap_i),
    .swi_i       (swi_i),
    .xirq_i      (xirq_i),
    .x_mask_i    (x_mask_i),
    .irq_valid_i (irq_valid),
    .irq_idx_i   (irq_idx),
    .i_mask_i    (i_mask_i),
    .pend_o      (req_pend_o),
    .off_o       (sel_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vec_addr_o <= {{BASE_W{1'b1}}, OFF_RST_PIN};
    else if (vec_fetch_i) vec_addr_o <= {base_q, sel_off};
  end

  assign low_pwr = stop_mode_i | wait_mode_i;
  // X-maskable line wakes regardless of the X bit
  assign wake_o  = low_pwr & (req_pend_o | xirq_i);

  p_vec_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_fetch_i |=> $stable(vec_addr_o));
  p_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && !req_pend_o) |=> vec_addr_o[OFF_W-1:0] == OFF_SPUR);
  p_xirq_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_pwr && xirq_i) |-> wake_o);
  p_no_wake_awake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_pwr |-> !wake_o);
  p_imask_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_mask_i && rst_src_i == 3'b000 && !trap_i && !swi_i && !xirq_i) |-> !req_pend_o);
  p_reset_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_fetch_i && rst_src_i[0]) |=> vec_addr_o[OFF_W-1:0] == OFF_RST_PIN);
endmodule

// File: tb/irq_vector_gen_bench.sv
module irq_vector_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rst_src = '0;
  logic        trap = 0, swi = 0, xirq = 0, i_mask = 0, x_mask = 0;
  logic [7:0]  irq = '0;
  logic        fetch = 0, stop_m = 0, wait_m = 0, wr_en = 0, wr_hi = 0;
  logic [7:0]  wr_data = '0;
  logic [15:0] vec;
  logic        pend, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_gen u_irq_vector_gen (
    .clk_i(clk), .rst_ni(rst_n), .rst_src_i(rst_src), .trap_i(trap), .swi_i(swi),
    .xirq_i(xirq), .irq_i(irq), .i_mask_i(i_mask), .x_mask_i(x_mask),
    .vec_fetch_i(fetch), .stop_mode_i(stop_m), .wait_mode_i(wait_m),
    .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .vec_addr_o(vec), .req_pend_o(pend), .wake_o(wake)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    @(negedge clk);
    rst_src = '0; trap = 0; swi = 0; xirq = 0; irq = '0;
    i_mask = 0; x_mask = 0; stop_m = 0; wait_m = 0;
  endtask

  task automatic do_fetch();
    @(negedge clk); fetch = 1;
    @(negedge clk); fetch = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 vec", vec, 16'hFFFE);
    check("R1 pend", {15'd0, pend}, 16'd0);
  endtask

  task automatic t_irq_prio();
    clear_inputs();
    irq = 8'b0000_0101; do_fetch(); check("R2 idx2", vec, 16'hFF86);
    check("R2 pend", {15'd0, pend}, 16'd1);
    irq = 8'b1000_0001; do_fetch(); check("R2 idx7", vec, 16'hFF90);
    irq = 8'b0000_0001; do_fetch(); check("R2 idx0", vec, 16'hFF82);
  endtask

  task automatic t_imask();
    clear_inputs();
    i_mask = 1; irq = 8'hFF; #1;
    check("R3 pend", {15'd0, pend}, 16'd0);
    do_fetch(); check("R3 spurious", vec, 16'hFF80);
  endtask

  task automatic t_xmask();
    clear_inputs();
    xirq = 1; irq = 8'hFF; do_fetch(); check("R4 xirq", vec, 16'hFFF4);
    x_mask = 1; do_fetch(); check("R4 masked", vec, 16'hFF90);
  endtask

  task automatic t_trap();
    clear_inputs();
    trap = 1; swi = 1; xirq = 1; irq = 8'hFF; i_mask = 1; x_mask = 1; #1;
    check("R5 pend", {15'd0, pend}, 16'd1);
    do_fetch(); check("R5 trap", vec, 16'hFFF8);
  endtask

  task automatic t_swi();
    clear_inputs();
    swi = 1; xirq = 1; i_mask = 1; x_mask = 1; do_fetch();
    check("R6 swi masked", vec, 16'hFFF6);
    x_mask = 0; do_fetch(); check("R6 over xirq", vec, 16'hFFF6);
  endtask

  task automatic t_resets();
    clear_inputs();
    trap = 1; swi = 1;
    rst_src = 3'b110; do_fetch(); check("R7 clkmon", vec, 16'hFFFC);
    rst_src = 3'b100; do_fetch(); check("R7 wdog", vec, 16'hFFFA);
    rst_src = 3'b111; do_fetch(); check("R7 pin", vec, 16'hFFFE);
  endtask

  task automatic t_base();
    clear_inputs();
    trap = 1;
    wr_en = 1; wr_hi = 1; wr_data = 8'h3C;
    @(negedge clk); wr_en = 0;
    do_fetch(); check("R8 high write", vec, 16'h3CF8);
    @(negedge clk); wr_en = 1; wr_hi = 0; wr_data = 8'h11;
    @(negedge clk); wr_en = 0;
    do_fetch(); check("R8 low ignored", vec, 16'h3CF8);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_data = 8'hFF;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_hold();
    clear_inputs();
    swi = 1; do_fetch(); check("R9 latch", vec, 16'hFFF6);
    @(negedge clk); swi = 0; rst_src = 3'b001;
    repeat (3) @(negedge clk);
    check("R9 hold", vec, 16'hFFF6);
    clear_inputs(); do_fetch(); check("R9 spurious", vec, 16'hFF80);
  endtask

  task automatic t_wake();
    clear_inputs();
    stop_m = 1; xirq = 1; x_mask = 1; #1;
    check("R10 xirq stop", {15'd0, wake}, 16'd1);
    @(negedge clk); stop_m = 0; #1;
    check("R10 awake", {15'd0, wake}, 16'd0);
    @(negedge clk); xirq = 0; wait_m = 1; irq = 8'h10; i_mask = 1; #1;
    check("R10 masked irq", {15'd0, wake}, 16'd0);
    @(negedge clk); i_mask = 0; #1;
    check("R10 irq wait", {15'd0, wake}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_irq_prio();
    t_imask();
    t_xmask();
    t_trap();
    t_swi();
    t_resets();
    t_base();
    t_hold();
    t_wake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule